// File: doc/BRIEF.md
# Unaligned Vector Load Aligner

This block sits between a memory array and a vector register file. A requester gives it a byte address with no alignment restriction and a count of consecutive 16-byte vectors. The block reads aligned 16-byte beats from memory through a plain synchronous read port whose data returns one cycle after the read strobe. It joins each pair of neighbouring beats in a byte rotator, and it presents aligned result vectors with a valid strobe and a last flag.

For a start address on a 16-byte boundary, each beat is one result, so N vectors cost N reads. For any other start address, each beat supplies the upper part of one result and the lower part of the next. The tail of the previous beat is kept, so N vectors cost N+1 reads instead of 2N. A single unaligned vector therefore takes two reads, and 64 bytes from an unaligned address take five.

Top module: `vload_aligner`

## Requirements
- R1: Byte i of result vector k (byte i at data bits [8i+7:8i]) equals memory byte (start address + 16k + i) for every start address, aligned or not.
- R2: When the low 4 address bits are zero, a request for N vectors issues exactly N reads.
- R3: When the low 4 address bits are non-zero, a request for N vectors issues exactly N+1 reads on consecutive cycles. A single such vector takes 2 reads and a 4-vector load takes 5.
- R4: Read addresses have their low 4 bits clear. The first equals the start address with those bits cleared, and each later read is 16 above the one before.
- R5: A request is taken only while busy is low. A request presented while busy is high has no effect on reads, results or busy.
- R6: Busy rises the cycle after a request is taken and falls in the same cycle as the vector carrying the last flag. A new request may be taken in that cycle.
- R7: Results come out in ascending address order, one per cycle. The first comes 2 cycles after the first read for an aligned start and 3 cycles after it otherwise. The last flag is set on the final vector only.
- R8: A request with a vector count of zero is ignored: no read is issued and busy stays low.
- R9: After reset, busy, the read strobe, the result valid and the last flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | AW | Byte address of the first vector |
| req_count | input | CW | Number of consecutive vectors |
| busy | output | 1 | High while a load is in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Aligned beat address |
| mem_rd_data | input | LANES*8 | Beat data, valid one cycle after the strobe |
| vec_valid | output | 1 | Result vector valid |
| vec_data | output | LANES*8 | Result vector, byte 0 at lowest address |
| vec_last | output | 1 | Marks the final vector of a request |

## Verification
A corrupted shift register would show in the first result of an unaligned load, three cycles after the first read, as bytes taken from the wrong offset. A wrong beat counter would show one cycle later or earlier as an extra or missing read strobe, or as a stray address outside the expected sequence. A wrong remaining-vector count would show as a last flag on the wrong vector, or as busy falling at the wrong time. The bench predicts the expected reads, results and busy for every cycle and compares them on every clock, so any such fault shows within the first cycle it affects.

// File: rtl/vla_pkg.sv
package vla_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fetch_state_e;

endpackage

// File: rtl/vla_fetch_seq.sv
module vla_fetch_seq
  import vla_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int LANES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW:0]   beats,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);

  localparam int OFFW = $clog2(LANES);

  fetch_state_e st_q;
  logic [CW:0]  rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FS_IDLE;
      rem_q   <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else if (start) begin
      rd_en   <= 1'b1;
      rd_addr <= {start_addr[AW-1:OFFW], {OFFW{1'b0}}};
      rem_q   <= beats - {{CW{1'b0}}, 1'b1};
      st_q    <= (beats > {{CW{1'b0}}, 1'b1}) ? FS_RUN : FS_IDLE;
    end else if (st_q == FS_RUN) begin
      rd_en   <= 1'b1;
      rd_addr <= rd_addr + AW'(LANES);
      rem_q   <= rem_q - {{CW{1'b0}}, 1'b1};
      if (rem_q == {{CW{1'b0}}, 1'b1}) st_q <= FS_IDLE;
    end else begin
      rd_en <= 1'b0;
    end
  end

  // R4
  rd_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[OFFW-1:0] == '0));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && !$past(start, 2)) |-> (rd_addr == $past(rd_addr) + AW'(LANES)));

endmodule

// File: rtl/vla_beat_pipe.sv
module vla_beat_pipe
  import vla_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      rd_en,
  input  logic [LANES*BYTE_W-1:0]   rd_data,
  input  logic [$clog2(LANES)-1:0]  shift,
  output logic                      emit,
  output logic [LANES*BYTE_W-1:0]   lo,
  output logic [LANES*BYTE_W-1:0]   hi
);

  logic                    rvalid_q;
  logic                    have_prev_q;
  logic [LANES*BYTE_W-1:0] prev_q;
  logic                    aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q    <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (start) begin
        have_prev_q <= 1'b0;
      end else if (rvalid_q) begin
        have_prev_q <= 1'b1;
        prev_q      <= rd_data;
      end
    end
  end

  assign aligned = (shift == '0);
  assign emit    = rvalid_q && (aligned || have_prev_q);
  assign lo      = aligned ? rd_data : prev_q;
  assign hi      = rd_data;

endmodule

// File: rtl/vla_byte_rotator.sv
module vla_byte_rotator
  import vla_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [LANES*BYTE_W-1:0]  lo,
  input  logic [LANES*BYTE_W-1:0]  hi,
  input  logic [$clog2(LANES)-1:0] shift,
  output logic [LANES*BYTE_W-1:0]  out
);

  localparam int OFFW = $clog2(LANES);

  logic [2*LANES*BYTE_W-1:0] cat;
  assign cat = {hi, lo};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFFW:0] idx;
    always_comb begin
      idx = (OFFW+1)'(i) + {1'b0, shift};
      out[i*BYTE_W +: BYTE_W] = cat[idx*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/vload_aligner.sv
module vload_aligner
  import vla_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [AW-1:0]           req_addr,
  input  logic [CW-1:0]           req_count,
  output logic                    busy,
  output logic                    mem_rd_en,
  output logic [AW-1:0]           mem_rd_addr,
  input  logic [LANES*BYTE_W-1:0] mem_rd_data,
  output logic                    vec_valid,
  output logic [LANES*BYTE_W-1:0] vec_data,
  output logic                    vec_last
);

  localparam int OFFW = $clog2(LANES);
  localparam int DW   = LANES * BYTE_W;

  logic            accept;
  logic [CW:0]     beats;
  logic [OFFW-1:0] shift_q;
  logic [CW-1:0]   left_q;
  logic            emit;
  logic [DW-1:0]   lo, hi, rot;

  assign accept = req_valid && !busy && (req_count != '0);
  assign beats  = {1'b0, req_count} + {{CW{1'b0}}, |req_addr[OFFW-1:0]};

  vla_fetch_seq #(.AW(AW), .CW(CW), .LANES(LANES)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_addr (req_addr),
    .beats      (beats),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_rd_addr)
  );

  vla_beat_pipe #(.LANES(LANES)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .rd_en   (mem_rd_en),
    .rd_data (mem_rd_data),
    .shift   (shift_q),
    .emit    (emit),
    .lo      (lo),
    .hi      (hi)
  );

  vla_byte_rotator #(.LANES(LANES)) u_rot (
    .lo    (lo),
    .hi    (hi),
    .shift (shift_q),
    .out   (rot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      shift_q   <= '0;
      left_q    <= '0;
      vec_valid <= 1'b0;
      vec_last  <= 1'b0;
      vec_data  <= '0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        shift_q <= req_addr[OFFW-1:0];
        left_q  <= req_count;
      end
      vec_valid <= emit;
      if (emit) begin
        vec_data <= rot;
        vec_last <= (left_q == CW'(1));
        left_q   <= left_q - CW'(1);
        if (left_q == CW'(1)) busy <= 1'b0;
      end else begin
        vec_last <= 1'b0;
      end
    end
  end

  // R5
  rd_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  // R6
  busy_fall_last_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (vec_valid && vec_last));

  // R7
  last_gap_chk: assert property (@(posedge clk) disable iff (rst)
    vec_last |=> !vec_valid);

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_count == '0) |=> !busy);

endmodule

// File: tb/vload_aligner_bench.sv
module vload_aligner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int LANES = 16;
  localparam int DW = LANES * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic          busy, mem_rd_en, vec_valid, vec_last;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data, vec_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vload_aligner #(.AW(AW), .CW(CW), .LANES(LANES)) u_vload_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .vec_valid(vec_valid), .vec_data(vec_data), .vec_last(vec_last)
  );

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [DW-1:0] span(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*8 +: 8] = mbyte(a + AW'(i));
    return v;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= span(mem_rd_addr);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW-1:0] exp_rd  [int];
  logic [DW-1:0] exp_vec [int];
  bit            exp_lst [int];
  int bstart = 0, bend = 0;
  int checks = 0, fails = 0;
  bit checking = 1'b0, done = 1'b0;

  function automatic bit model_busy(input int j);
    return (j >= bstart) && (j < bend);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) if (checking) begin
    if (exp_rd.exists(cyc))
      check(mem_rd_en && mem_rd_addr == exp_rd[cyc], "R2/R3/R4 read", {mem_rd_en, mem_rd_addr}, {1'b1, exp_rd[cyc]});
    else
      check(!mem_rd_en, "R2/R3/R5/R8 no read", DW'(mem_rd_en), '0);
    if (exp_vec.exists(cyc)) begin
      check(vec_valid && vec_data == exp_vec[cyc], "R1/R7 vector", vec_data, exp_vec[cyc]);
      check(vec_last == exp_lst[cyc], "R7 last flag", DW'(vec_last), DW'(exp_lst[cyc]));
    end else begin
      check(!vec_valid && !vec_last, "R7 idle output", DW'({vec_valid, vec_last}), '0);
    end
    check(busy == model_busy(cyc), "R6 busy", DW'(busy), DW'(model_busy(cyc)));
  end

  task automatic send(input logic [AW-1:0] a, input int n);
    int sh, nb, first;
    req_valid = 1'b1;
    req_addr  = a;
    req_count = CW'(n);
    if (!model_busy(cyc) && n != 0) begin
      sh    = int'(a[3:0]);
      nb    = n + ((sh != 0) ? 1 : 0);
      for (int b = 0; b < nb; b++) exp_rd[cyc+1+b] = {a[AW-1:4], 4'h0} + AW'(16*b);
      first = cyc + 3 + ((sh != 0) ? 1 : 0);
      for (int v = 0; v < n; v++) begin
        exp_vec[first+v] = span(a + AW'(16*v));
        exp_lst[first+v] = (v == n-1);
      end
      bstart = cyc + 1;
      bend   = first + n - 1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (cyc <= bend + 2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1'b1;
    fails++; checks++;
    $display("FAIL watchdog cycle %0d actual=hung expected=finished", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!busy && !mem_rd_en && !vec_valid && !vec_last, "R9 reset",
          DW'({busy, mem_rd_en, vec_valid, vec_last}), '0);
    checking = 1'b1;
    send(32'h100, 1); drain();   // R2 aligned single
    send(32'h205, 1); drain();   // R3 unaligned single: 2 reads
    send(32'h303, 4); drain();   // R3 64 bytes unaligned: 5 reads
    send(32'h400, 4); drain();   // R2 aligned multi
    send(32'h50F, 3); drain();   // R1 maximum shift
    send(32'h601, 2); drain();   // R1 minimum shift
    send(32'h700, 0);            // R8 zero count
    repeat (5) @(negedge clk);
    send(32'h813, 6);            // R5 busy-time requests below are ignored
    send(32'h900, 2);
    send(32'hA07, 3);
    while (cyc < bend) @(negedge clk);
    send(32'hB0A, 2);            // R6 accepted in the cycle of the last flag
    drain();
    for (int k = 0; k < 6; k++) begin
      send(AW'(32'h1000 + 37*k), 1 + (k % 4));
      drain();
    end
    checking = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule